// File: doc/BRIEF.md
# Quad DAC Serial Command Front End

This block is the digital control side of a four-channel digital-to-analog converter. A host drives a three-wire serial port: a serial clock, a data line, and an active-low select line whose rising edge also acts as the load strobe. Bits move, MSB first, into a 32-bit shift register on serial clock rising edges while the select line is low. When the select line returns high, the block decodes the most recent 24 bits into a command, a channel address and a 16-bit data field, then acts on the four channels.

Each channel has two stages of storage. An input stage receives data. A conversion stage holds the code that the converter uses. Each channel also has a power-down flag. The shift register's oldest bit appears on a serial output that changes on serial clock falling edges, so several parts can share one port in a chain. An active-low clear input returns every channel to zero scale.

The serial pins are sampled by the block's system clock through synchronizers. Edges are detected in that clock domain. The resolution parameter selects a 16-, 14- or 12-bit code. That code is taken left-justified from the data field.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: After reset every channel code is zero, every power-down flag is 0, and the serial output is 0.
- R2: Bits on the data line are shifted in on serial clock rising edges while select is low. When select rises, only the 24 most recent bits are decoded: command in bits 23..20, address in bits 19..16, data in bits 15..0. Bits received earlier than those have no effect.
- R3: The serial output carries the bit that entered 32 rising edges earlier. It changes only after a serial clock falling edge.
- R4: Command 0000 loads the data into the input stage of the addressed channel(s). Their codes stay unchanged.
- R5: Command 0001 copies the input stage into the code of the addressed channel(s).
- R6: Command 0010 loads the data into the addressed channel's input stage, then copies the input stage into the code of all four channels.
- R7: Command 0011 loads the data into both stages of the addressed channel(s).
- R8: Command 0100 sets the power-down flag of the addressed channel(s). It ignores the data field and leaves both stages of every channel unchanged.
- R9: Any command that updates a channel's code (0001, 0010, 0011) clears that channel's power-down flag.
- R10: Command 1111 and the unused command codes change nothing. Address 0..3 selects channel 0..3, address 1111 selects all channels, and addresses 0100..1110 select none.
- R11: While the clear input is low, both stages of every channel read zero. Power-down flags keep their values.
- R12: With a resolution of N bits, the code is data bits 15 down to 16-N. The lower bits are ignored.
- R13: Serial clock edges while select is high do not alter the shift register. A select pulse with no clock edges executes the word already held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_ld_n | input | 1 | Active-low select; its rising edge executes the word |
| clr_n | input | 1 | Active-low clear to zero scale |
| sdo | output | 1 | Serial data out for chaining |
| dac_code | output | NCH*DATA_W | Channel codes, channel 0 in the low bits |
| dac_pd | output | NCH | Power-down flag for each channel |

## Verification
The main decode path is tried with single-channel and all-channel addresses under every implemented command. The data values chosen separate the input stage from the code stage, so a write that leaks into the code stage, or an update that reads the wrong stage, shows up at the outputs. Frames carry junk in the upper byte and in the ignored low nibble, and one frame is 64 bits long; together these show whether only the last 24 bits are decoded and whether the serial output delays by exactly 32 edges. A clear followed by a select pulse with no clocks and junk clocked while select is high separates a shift register that honours the select line from one that does not.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRAME_W = 32;
  localparam int WORD_W  = 24;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 4;
  localparam int FIELD_W = 16;

  localparam int CMD_LSB  = FIELD_W + ADDR_W;
  localparam int ADDR_LSB = FIELD_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_WR_IN      = 4'b0000,
    CMD_UPD        = 4'b0001,
    CMD_WR_UPD_ALL = 4'b0010,
    CMD_WR_UPD     = 4'b0011,
    CMD_PWR_DN     = 4'b0100,
    CMD_NOP        = 4'b1111
  } cmd_e;

  localparam logic [ADDR_W-1:0] ADDR_ALL = 4'b1111;
endpackage

// File: rtl/qdac_rst_sync.sv
module qdac_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic r0_q, r1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      r0_q <= 1'b0;
      r1_q <= 1'b0;
    end else begin
      r0_q <= 1'b1;
      r1_q <= r0_q;
    end
  end

  assign rst_n_o = r1_q;
endmodule

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
  import qdac_pkg::*;
#(
  parameter int LEN = FRAME_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sck_s,
  input  logic           sdi_s,
  input  logic           csn_s,
  output logic [LEN-1:0] frame,
  output logic           sdo,
  output logic           exec
);
  logic           sck_q, csn_q;
  logic [LEN-1:0] frame_q, frame_d;
  logic           sdo_q, sdo_d;
  logic           sck_rise, sck_fall, shift_en;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign shift_en = sck_rise & ~csn_s;
  assign exec     = csn_s & ~csn_q;

  always_comb begin
    frame_d = frame_q;
    sdo_d   = sdo_q;
    if (shift_en) frame_d = {frame_q[LEN-2:0], sdi_s};
    if (sck_fall) sdo_d = frame_q[LEN-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      csn_q <= csn_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else if (shift_en) frame_q <= frame_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdo_q <= 1'b0;
    else if (sck_fall) sdo_q <= sdo_d;
  end

  assign frame = frame_q;
  assign sdo   = sdo_q;

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sdo_q));
  // R3
  sdo_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |=> sdo_q == $past(frame_q[LEN-1]));
  // R13
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> $stable(frame_q));
  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> frame_q[0] == $past(sdi_s));
endmodule

// File: rtl/qdac_decoder.sv
module qdac_decoder
  import qdac_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic               exec,
  input  logic [WORD_W-1:0]  word,
  output logic [NCH-1:0]     wr_in,
  output logic [NCH-1:0]     upd,
  output logic [NCH-1:0]     pd_set,
  output logic [FIELD_W-1:0] field
);
  logic [CMD_W-1:0]  cmd;
  logic [ADDR_W-1:0] addr;
  logic [NCH-1:0]    sel;

  assign cmd   = word[CMD_LSB +: CMD_W];
  assign addr  = word[ADDR_LSB +: ADDR_W];
  assign field = word[FIELD_W-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_ALL) || (addr == ADDR_W'(i));
  end

  always_comb begin
    wr_in  = '0;
    upd    = '0;
    pd_set = '0;
    if (exec) begin
      case (cmd)
        CMD_WR_IN: wr_in = sel;
        CMD_UPD:   upd = sel;
        CMD_WR_UPD_ALL: begin
          wr_in = sel;
          upd   = '1;
        end
        CMD_WR_UPD: begin
          wr_in = sel;
          upd   = sel;
        end
        CMD_PWR_DN: pd_set = sel;
        default: ;
      endcase
    end
  end

  // R10
  always_comb begin
    if (!exec) begin
      strobe_idle_chk: assert ((wr_in | upd | pd_set) == '0);
    end
  end

  // R8
  always_comb begin
    pd_excl_chk: assert ((pd_set & (upd | wr_in)) == '0);
  end
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel
  import qdac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr,
  input  logic               upd,
  input  logic               pd_set,
  input  logic [FIELD_W-1:0] field,
  output logic [DATA_W-1:0]  code,
  output logic               pd
);
  logic [DATA_W-1:0] in_q, in_d, dac_q, dac_d, din;
  logic              pd_q, pd_d;
  logic              in_en, dac_en, pd_en;

  assign din    = field[FIELD_W-1 -: DATA_W];
  assign in_en  = clr | wr;
  assign dac_en = clr | upd;
  assign pd_en  = upd | pd_set;

  always_comb begin
    in_d  = wr ? din : in_q;
    dac_d = in_d;
    if (clr) begin
      in_d  = '0;
      dac_d = '0;
    end
    pd_d = ~upd & pd_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= '0;
    else if (in_en) in_q <= in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_q <= '0;
    else if (dac_en) dac_q <= dac_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 1'b0;
    else if (pd_en) pd_q <= pd_d;
  end

  assign code = dac_q;
  assign pd   = pd_q;

  // R8
  pd_keeps_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_set && !clr |=> $stable(in_q) && $stable(dac_q));
  // R9
  upd_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !pd_q);
  // R8
  pd_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_set && !upd |=> pd_q);
  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> dac_q == '0 && in_q == '0);
  // R4
  wr_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !upd && !clr |=> $stable(dac_q));
  // R5
  upd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !wr && !clr |=> dac_q == $past(in_q));
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
  import qdac_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck,
  input  logic                  sdi,
  input  logic                  cs_ld_n,
  input  logic                  clr_n,
  output logic                  sdo,
  output logic [NCH*DATA_W-1:0] dac_code,
  output logic [NCH-1:0]        dac_pd
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1100;

  logic                rst_s_n;
  logic [NSYNC-1:0]    pins_s;
  logic                sck_s, sdi_s, csn_s, clr_s_n;
  logic [FRAME_W-1:0]  frame;
  logic                exec;
  logic [NCH-1:0]      wr_in, upd, pd_set;
  logic [FIELD_W-1:0]  field;

  qdac_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_s_n)
  );

  qdac_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     ({clr_n, cs_ld_n, sdi, sck}),
    .q     (pins_s)
  );

  assign {clr_s_n, csn_s, sdi_s, sck_s} = pins_s;

  qdac_shifter #(.LEN(FRAME_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_s_n),
    .sck_s (sck_s),
    .sdi_s (sdi_s),
    .csn_s (csn_s),
    .frame (frame),
    .sdo   (sdo),
    .exec  (exec)
  );

  qdac_decoder #(.NCH(NCH)) u_dec (
    .exec   (exec),
    .word   (frame[WORD_W-1:0]),
    .wr_in  (wr_in),
    .upd    (upd),
    .pd_set (pd_set),
    .field  (field)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    qdac_channel #(.DATA_W(DATA_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .clr    (~clr_s_n),
      .wr     (wr_in[i]),
      .upd    (upd[i]),
      .pd_set (pd_set[i]),
      .field  (field),
      .code   (dac_code[i*DATA_W +: DATA_W]),
      .pd     (dac_pd[i])
    );
  end

  // R10
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    exec && frame[CMD_LSB +: CMD_W] == CMD_NOP && clr_s_n
    |=> $stable(dac_code) && $stable(dac_pd));
  // R13
  no_exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !exec && clr_s_n |=> $stable(dac_code) && $stable(dac_pd));
endmodule

// File: tb/tb_qdac_serial_ctrl.sv
`timescale 1ns/1ps
module tb_qdac_serial_ctrl;
  localparam int NCH = 4;
  localparam int DW  = 12;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n, sck, sdi, cs_ld_n, clr_n;
  logic sdo;
  logic [NCH*DW-1:0] dac_code;
  logic [NCH-1:0] dac_pd;

  always #2 clk = ~clk;

  qdac_serial_ctrl #(.NCH(NCH), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .cs_ld_n(cs_ld_n),
    .clr_n(clr_n), .sdo(sdo), .dac_code(dac_code), .dac_pd(dac_pd)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_in [NCH];
  logic [DW-1:0] m_dac[NCH];
  logic          m_pd [NCH];

  string             q_req [$];
  logic [NCH*DW-1:0] q_code[$];
  logic [NCH-1:0]    q_pd  [$];
  event exp_ev;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(exp_ev);
      while (q_req.size() > 0) begin
        string r;
        logic [NCH*DW-1:0] ec;
        logic [NCH-1:0] ep;
        r  = q_req.pop_front();
        ec = q_code.pop_front();
        ep = q_pd.pop_front();
        chk({r, " code"}, 64'(dac_code), 64'(ec));
        chk({r, " pd"}, 64'(dac_pd), 64'(ep));
      end
    end
  end

  task automatic push_exp(input string req);
    logic [NCH*DW-1:0] c;
    logic [NCH-1:0] p;
    for (int i = 0; i < NCH; i++) begin
      c[i*DW +: DW] = m_dac[i];
      p[i] = m_pd[i];
    end
    q_req.push_back(req);
    q_code.push_back(c);
    q_pd.push_back(p);
    -> exp_ev;
  endtask

  // reference model from the requirements
  task automatic model_apply(input logic [23:0] w);
    logic [3:0] cmd, addr;
    logic [DW-1:0] d;
    cmd  = w[23:20];
    addr = w[19:16];
    d    = w[15 -: DW];
    for (int i = 0; i < NCH; i++) begin
      bit s;
      s = (addr == 4'hF) || (addr == 4'(i));
      case (cmd)
        4'h0: if (s) m_in[i] = d;
        4'h1: if (s) begin m_dac[i] = m_in[i]; m_pd[i] = 1'b0; end
        4'h2: if (s) m_in[i] = d;
        4'h3: if (s) begin m_in[i] = d; m_dac[i] = d; m_pd[i] = 1'b0; end
        4'h4: if (s) m_pd[i] = 1'b1;
        default: ;
      endcase
    end
    if (cmd == 4'h2)
      for (int i = 0; i < NCH; i++) begin
        m_dac[i] = m_in[i];
        m_pd[i] = 1'b0;
      end
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic end_frame();
    repeat (HALF) @(negedge clk);
    cs_ld_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] w, input string req);
    cs_ld_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
    end_frame();
    model_apply(w[23:0]);
    push_exp(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w1, w2;
    for (int i = 0; i < NCH; i++) begin
      m_in[i] = '0; m_dac[i] = '0; m_pd[i] = 1'b0;
    end
    rst_n = 1'b0; sck = 1'b0; sdi = 1'b0; cs_ld_n = 1'b1; clr_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    push_exp("R1");
    chk("R1 sdo", 64'(sdo), 64'd0);

    // R4 write input only, junk upper byte (R2)
    frame(32'hA5_01ABC0, "R4 R2");
    // R5 update ch1 from input
    frame(32'h3C_11_0000, "R5");
    // R7 + R12 write and update ch2, low nibble junk
    frame(32'hFF_32_123F, "R7 R12");
    // R8 power down ch1, data ignored
    frame(32'h00_41_FFFF, "R8");
    // R10 nop, reserved command, unselected address
    frame(32'h00_F1_5550, "R10 nop");
    frame(32'h00_70_6660, "R10 reserved");
    frame(32'h00_35_7770, "R10 addr");
    // R9 update wakes ch1, input kept through power-down (R8)
    frame(32'h00_11_0000, "R9 R8");
    // R6 all-address write then write-and-update-all
    frame(32'h00_0F_7770, "R4 all");
    frame(32'h00_20_9990, "R6");
    // power all down, then update only ch3
    frame(32'h00_4F_0000, "R8 all");
    frame(32'h00_33_4440, "R9 ch3");

    // R11 clear
    clr_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    push_exp("R11");
    clr_n = 1'b1;
    repeat (6) @(negedge clk);

    // R13 junk clocks with select high are ignored, then bare select pulse
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    cs_ld_n = 1'b0;
    repeat (6) @(negedge clk);
    cs_ld_n = 1'b1;
    repeat (10) @(negedge clk);
    model_apply(24'h33_4440);
    push_exp("R13");

    // R3 + R2: 64-bit frame, sdo delayed by 32 edges, last word decoded
    w1 = 32'hDEAD_BEEF;
    w2 = 32'h5A_30_8880;
    cs_ld_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 1; k <= 64; k++) begin
      logic b;
      b = (k <= 32) ? w1[32-k] : w2[64-k];
      sdi = b;
      repeat (HALF) @(negedge clk);
      if (k >= 33) chk($sformatf("R3 bit %0d", k), 64'(sdo), 64'(w1[32-(k-32)]));
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    chk("R3 last", 64'(sdo), 64'(w2[31]));
    end_frame();
    model_apply(w2[23:0]);
    push_exp("R2 R3 long");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule